// File: doc/BRIEF.md
# Sparse Polynomial Nonlinear Equalizer

This block is a streaming datapath that sits after an ADC and removes receiver distortion from the sampled data. It accepts one offset-binary sample per clock, qualified by a valid strobe. It turns the sample into a signed value and builds the second, third and fourth powers of that value. All four powers are kept in a 16-deep history of past samples.

Five term engines run in parallel. Each one picks one power of a delayed sample and multiplies it by a second delayed copy of the plain sample. It then weights the product with a programmable coefficient and scales the result down by a programmable power of two. A final adder sums the five terms with a latency-matched, separately scaled copy of the linear input. The sum is rounded and saturated to 16 bits.

Coefficients, delays, power selects and shift amounts are written through a small register port. A write is held in a shadow copy and takes effect only at a clean sample boundary.

Top module: `poly_nleq`

## Requirements
- R1: The 12-bit input code is read as offset binary and becomes the signed value code − 2048, which is the same as inverting its MSB. Code 0x800 maps to 0, 0x000 maps to −2048 and 0xFFF maps to +2047.
- R2: `out_valid` follows `in_valid` exactly 5 clock edges later, with one result per accepted sample. Gaps in the input stream appear unchanged at the output.
- R3: During and right after reset, `out_valid` and `out_data` are 0. All coefficients, delays, selects and shifts are 0, and the sample history is 0. Under this setting every output equals the signed input value times 16.
- R4: Powers use a normalised product nm(a,b) = floor(a·b / 2048). They are x² = nm(x,x), x³ = nm(x²,x) and x⁴ = nm(x³,x).
- R5: Term i forms p = nm(P[s](n−d1), x(n−d2)). The select s uses 0 for x, 1 for x², 2 for x³ and 3 for x⁴. The delays d1 and d2 run from 0 to 15 and count accepted samples only, not clock cycles.
- R6: Term i contributes floor(p·c / 2^k), where c is its signed 16-bit coefficient and k its shift from 0 to 15. The linear path contributes floor(x·2^15 / 2^kL), where kL is its own shift.
- R7: The output is floor((sum + 1024) / 2048), clamped to the range −32768 to +32767.
- R8: Register map. Address 2i (i = 0..4) holds the coefficient of term i. Address 2i+1 holds the fields of term i: d1 in bits 3:0, d2 in bits 7:4, s in bits 9:8 and k in bits 13:10. Address 10 holds kL in bits 3:0.
- R9: Register writes go to a shadow copy. The shadow is applied only at a clock edge where no sample was accepted at either of the two preceding edges. While samples arrive every cycle, the old settings stay in force. Every output is computed from a single setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_code | input | 12 | Offset-binary ADC code |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Equalized signed output |

## Verification
The hardest situation to reach from the ports is a register write that lands while samples are in flight. To get there, the bench writes a new coefficient in the middle of an unbroken stream. It then checks that every later output of that stream still matches the old setting. It also checks that samples sent after a short idle gap use the new setting. Long delays and the fourth-power select are reached by programming delays of 15 and running pseudo-random streams with gaps, so history taps far from the newest sample feed the products. Saturation at both rails is forced with full-scale codes and a maximum coefficient on the fifth-order term.

// File: rtl/nleq_pkg.sv
package nleq_pkg;
  parameter int SW = 12;   // sample width
  parameter int CW = 16;   // coefficient width, also register data width
  parameter int AW = 32;   // accumulator width
  parameter int OW = 16;   // output width
  parameter int NT = 5;    // number of term engines
  parameter int HD = 16;   // history depth
  parameter int NP = 4;    // number of powers kept
  parameter int SHW = 4;   // shift field width

  localparam int NW   = SW + 1;            // normalised value width
  localparam int DW   = $clog2(HD);
  localparam int SELW = $clog2(NP);
  localparam int FRAC = SW - 1;
  localparam int CFR  = CW - 1;
  localparam int FW   = SHW + SELW + 2 * DW; // packed field bits of a term
  localparam int AAW  = $clog2(2 * NT + 1);

  typedef logic signed [NW-1:0] nv_t;

  typedef struct packed {
    logic [CW-1:0]   coef;
    logic [SHW-1:0]  shift;
    logic [SELW-1:0] sel;
    logic [DW-1:0]   d2;
    logic [DW-1:0]   d1;
  } term_cfg_t;

  function automatic nv_t nmul(input nv_t a, input nv_t b);
    logic signed [2*NW-1:0] p;
    logic signed [2*NW-1:0] q;
    p = a * b;
    q = p >>> FRAC;
    return q[NW-1:0];
  endfunction
endpackage

// File: rtl/nleq_front.sv
module nleq_front
  import nleq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_code,
  output logic          hist_vld,
  output nv_t           hist_o [NP][HD]
);
  logic v1_q;
  nv_t  x1_q, x_cv;
  nv_t  pw [NP];
  nv_t  hist_q [NP][HD];
  nv_t  hist_d [NP][HD];

  always_comb begin
    x_cv  = nv_t'($signed({~in_code[SW-1], in_code[SW-2:0]}));
    pw[0] = x1_q;
    for (int k = 1; k < NP; k++) pw[k] = nmul(pw[k-1], x1_q);
    hist_d = hist_q;
    if (v1_q) begin
      for (int k = 0; k < NP; k++) begin
        hist_d[k][0] = pw[k];
        for (int j = 1; j < HD; j++) hist_d[k][j] = hist_q[k][j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q     <= 1'b0;
      x1_q     <= '0;
      hist_vld <= 1'b0;
      hist_q   <= '{default: '0};
    end else begin
      v1_q     <= in_valid;
      if (in_valid) x1_q <= x_cv;
      hist_vld <= v1_q;
      hist_q   <= hist_d;
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/nleq_term.sv
module nleq_term
  import nleq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_p,
  input  logic                 en_w,
  input  nv_t                  hist [NP][HD],
  input  term_cfg_t            cfg,
  output logic signed [AW-1:0] w_o
);
  nv_t p_q, p_d;
  logic signed [NW+CW-1:0] prod;
  logic signed [AW-1:0]    ext, w_d;

  always_comb begin
    p_d  = nmul(hist[cfg.sel][cfg.d1], hist[0][cfg.d2]);
    prod = p_q * $signed(cfg.coef);
    ext  = prod;
    w_d  = ext >>> cfg.shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      w_o <= '0;
    end else begin
      if (en_p) p_q <= p_d;
      if (en_w) w_o <= w_d;
    end
  end
endmodule

// File: rtl/nleq_cfg.sv
module nleq_cfg
  import nleq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AAW-1:0] addr,
  input  logic [CW-1:0]  wdata,
  input  logic           hold,
  output term_cfg_t      act [NT],
  output logic [SHW-1:0] lin_shift
);
  term_cfg_t      sh_q [NT];
  term_cfg_t      sh_d [NT];
  term_cfg_t      act_d [NT];
  logic [SHW-1:0] lsh_sq, lsh_sd, lsh_d;
  logic           pend_q, pend_d, commit;

  always_comb begin
    sh_d   = sh_q;
    lsh_sd = lsh_sq;
    if (we) begin
      for (int i = 0; i < NT; i++) begin
        if (addr == AAW'(2 * i))     sh_d[i].coef = wdata;
        if (addr == AAW'(2 * i + 1)) sh_d[i][FW-1:0] = wdata[FW-1:0];
      end
      if (addr == AAW'(2 * NT)) lsh_sd = wdata[SHW-1:0];
    end
    commit = pend_q & ~hold;
    pend_d = we | (pend_q & ~commit);
    act_d  = commit ? sh_q : act;
    lsh_d  = commit ? lsh_sq : lin_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '{default: '0};
      act       <= '{default: '0};
      lsh_sq    <= '0;
      lin_shift <= '0;
      pend_q    <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      act       <= act_d;
      lsh_sq    <= lsh_sd;
      lin_shift <= lsh_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/poly_nleq.sv
module poly_nleq
  import nleq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [SW-1:0]  in_code,
  input  logic           cfg_we,
  input  logic [AAW-1:0] cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  output logic           out_valid,
  output logic [OW-1:0]  out_data
);
  localparam int TCW = $bits(term_cfg_t);
  localparam logic signed [AW-1:0] RND  = 1 <<< (FRAC - 1);
  localparam logic signed [AW-1:0] OMAX = (1 <<< (OW - 1)) - 1;
  localparam logic signed [AW-1:0] OMIN = -(1 <<< (OW - 1));

  logic                 v2_w, v3_q, v4_q;
  nv_t                  hist [NP][HD];
  term_cfg_t            act [NT];
  logic [SHW-1:0]       lsh;
  logic signed [AW-1:0] w_a [NT];
  nv_t                  lin3_q;
  logic signed [AW-1:0] lin_ext, lin_d, lin4_q;
  logic signed [AW-1:0] acc, rnd, scl;
  logic [OW-1:0]        out_d;
  logic [NT*TCW+SHW-1:0] act_flat;

  nleq_front u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .hist_vld(v2_w), .hist_o(hist)
  );

  nleq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hold(v2_w | v3_q), .act(act), .lin_shift(lsh)
  );

  for (genvar i = 0; i < NT; i++) begin : g_term
    nleq_term u_term (
      .clk(clk), .rst_n(rst_n), .en_p(v2_w), .en_w(v3_q),
      .hist(hist), .cfg(act[i]), .w_o(w_a[i])
    );
    assign act_flat[i*TCW +: TCW] = act[i];
  end
  assign act_flat[NT*TCW +: SHW] = lsh;

  always_comb begin
    lin_ext = lin3_q;
    lin_d   = (lin_ext <<< CFR) >>> lsh;
    acc     = lin4_q;
    for (int i = 0; i < NT; i++) acc = acc + w_a[i];
    rnd = acc + RND;
    scl = rnd >>> FRAC;
    if (scl > OMAX)      out_d = OMAX[OW-1:0];
    else if (scl < OMIN) out_d = OMIN[OW-1:0];
    else                 out_d = scl[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v3_q      <= 1'b0;
      v4_q      <= 1'b0;
      out_valid <= 1'b0;
      lin3_q    <= '0;
      lin4_q    <= '0;
      out_data  <= '0;
    end else begin
      v3_q      <= v2_w;
      v4_q      <= v3_q;
      out_valid <= v4_q;
      if (v2_w) lin3_q   <= hist[0][0];
      if (v3_q) lin4_q   <= lin_d;
      if (v4_q) out_data <= out_d;
    end
  end
endmodule

// File: rtl/nleq_chk.sv
module nleq_chk
  import nleq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data,
  input logic          v2,
  input logic          v3,
  input logic [NT*$bits(term_cfg_t)+SHW-1:0] act
);
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt != 5) cnt <= cnt + 3'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R3: assert (!out_valid && out_data == '0);
  end

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 5) |-> (out_valid == $past(in_valid, 5)));

  assert_data_only_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 0 && !$stable(out_data)) |-> out_valid);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 || v3) |=> $stable(act));
endmodule

bind poly_nleq nleq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .v2(v2_w), .v3(v3_q), .act(act_flat)
);

// File: tb/tb_poly_nleq.sv
`timescale 1ns/1ps
module tb_poly_nleq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_code;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        out_valid;
  logic [15:0] out_data;

  poly_nleq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  // {code, expected output} under the reset setting (R1, R3)
  localparam logic [27:0] TAB [9] = '{
    {12'h800, 16'h0000}, {12'h000, 16'h8000}, {12'hFFF, 16'h7FF0},
    {12'h801, 16'h0010}, {12'h7FF, 16'hFFF0}, {12'hC00, 16'h4000},
    {12'h400, 16'hC000}, {12'h123, 16'h9230}, {12'hABC, 16'h2BC0}
  };

  int nchk = 0, nfail = 0, cyc = 0;
  int mh [4][16];
  int mcoef [5], md1 [5], md2 [5], msel [5], msh [5];
  int mlsh;
  int expq [2048];
  int tq [2048];
  string rq [2048];
  int wp = 0, rp = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int nm(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p >>> 11);
  endfunction

  task automatic calc(input logic [11:0] c, output int e);
    int x;
    int pw [4];
    longint acc;
    x = int'(c) - 2048;
    pw[0] = x;
    for (int k = 1; k < 4; k++) pw[k] = nm(pw[k-1], x);
    for (int k = 0; k < 4; k++) begin
      for (int j = 15; j > 0; j--) mh[k][j] = mh[k][j-1];
      mh[k][0] = pw[k];
    end
    acc = (longint'(x) <<< 15) >>> mlsh;
    for (int i = 0; i < 5; i++)
      acc += (longint'(nm(mh[msel[i]][md1[i]], mh[0][md2[i]])) * mcoef[i]) >>> msh[i];
    acc = (acc + 1024) >>> 11;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    e = int'(acc);
  endtask

  task automatic push(input int e, input string req);
    expq[wp % 2048] = e;
    tq[wp % 2048]   = cyc;
    rq[wp % 2048]   = req;
    wp++;
  endtask

  task automatic send(input logic [11:0] c, input string req);
    int e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_code = c; cfg_we = 1'b0;
    calc(c, e);
    push(e, req);
  endtask

  task automatic send_tab(input logic [11:0] c, input int e, input string req);
    int dummy;
    @(posedge clk); #1;
    in_valid = 1'b1; in_code = c; cfg_we = 1'b0;
    calc(c, dummy);
    push(e, req);
  endtask

  task automatic send_wr(input logic [11:0] c, input logic [3:0] a, input logic [15:0] d);
    int e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_code = c;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    calc(c, e);
    push(e, "R9 old setting kept in stream");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // R8 field layout: d1[3:0] d2[7:4] s[9:8] k[13:10]
  task automatic prog(input int i, input int c, input int d1, input int d2,
                      input int s, input int k);
    wr(4'(2 * i), 16'(c));
    wr(4'(2 * i + 1), {2'b00, 4'(k), 2'(s), 4'(d2), 4'(d1)});
    mcoef[i] = c; md1[i] = d1; md2[i] = d2; msel[i] = s; msh[i] = k;
  endtask

  task automatic prog_lin(input int k);
    wr(4'd10, 16'(k));
    mlsh = k;
  endtask

  function automatic logic [11:0] nxt();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[11:0];
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rp == wp) begin
        chk(1'b0, "R2 unexpected output", int'($signed(out_data)), 0);
      end else begin
        chk(int'($signed(out_data)) == expq[rp % 2048], rq[rp % 2048],
            int'($signed(out_data)), expq[rp % 2048]);
        chk(cyc - tq[rp % 2048] == 5, "R2 latency", cyc - tq[rp % 2048], 5);
        rp++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 16; j++) mh[k][j] = 0;
    for (int i = 0; i < 5; i++) begin
      mcoef[i] = 0; md1[i] = 0; md2[i] = 0; msel[i] = 0; msh[i] = 0;
    end
    mlsh = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 reset valid", int'(out_valid), 0);
    chk(out_data == 16'h0, "R3 reset data", int'(out_data), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 idle after reset", int'(out_valid), 0);

    // Table walk under reset setting: R1 conversion and R3 pass-through
    for (int t = 0; t < 9; t++)
      send_tab(TAB[t][27:16], int'($signed(TAB[t][15:0])), "R1 code conversion");
    idle(8);
    // Same table with gaps: R2 gap preservation
    for (int t = 0; t < 9; t++) begin
      send_tab(TAB[t][27:16], int'($signed(TAB[t][15:0])), "R2 gapped stream");
      if (t % 2 == 0) idle(t % 3 + 1);
    end
    idle(8);

    // Mixed setting: R4 powers, R5 delays and selects, R6 shifts, R7 rounding
    prog(0, 16384, 0, 0, 1, 0);
    prog(1, -8192, 3, 7, 0, 1);
    prog(2, 32767, 15, 15, 2, 2);
    prog(3, -32768, 1, 0, 3, 0);
    prog(4, 1000, 0, 15, 0, 15);
    prog_lin(1);
    for (int n = 0; n < 60; n++) begin
      send(nxt(), "R5 term products");
      if (n % 7 == 6) idle(1 + n % 3);
    end
    send(12'hFFF, "R4 full-scale positive");
    send(12'hFFF, "R4 full-scale positive");
    send(12'h000, "R4 full-scale negative");
    send(12'h000, "R4 full-scale negative");
    for (int n = 0; n < 20; n++) send(nxt(), "R6 scaled terms");
    idle(8);

    // Saturation: only the fifth-order term, maximum coefficient
    for (int i = 1; i < 5; i++) prog(i, 0, 0, 0, 0, 0);
    prog(0, 32767, 0, 0, 3, 0);
    prog_lin(0);
    send_tab(12'hFFF, 32767, "R7 positive clamp");
    send_tab(12'h000, -32768, "R7 negative clamp");
    send_tab(12'h800, 0, "R7 zero inside clamp setting");
    send_tab(12'hFFF, 32767, "R7 positive clamp");
    idle(8);

    // Deferred setting: R9
    prog(0, 12000, 2, 5, 1, 3);
    prog(1, -20000, 15, 1, 2, 0);
    prog_lin(2);
    for (int n = 0; n < 6; n++) send(nxt(), "R9 before write");
    send_wr(nxt(), 4'd0, 16'h8000);
    for (int n = 0; n < 25; n++) send(nxt(), "R9 old setting kept in stream");
    idle(3);
    mcoef[0] = -32768;
    for (int n = 0; n < 25; n++) send(nxt(), "R9 new setting after gap");
    idle(10);

    chk(rp == wp, "R2 all results delivered", rp, wp);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule